// File: doc/BRIEF.md
# Multi-lane vector execution sequencer

This block is a small vector coprocessor placed next to a scalar core. It holds eight vector registers of four 32-bit elements each and a length register that says how many leading elements a vector instruction touches. Four operations are available: fill a vector register from consecutive words of an internal word memory, write a vector register out to consecutive words of that memory, multiply every element of a vector by a scalar, and add two vectors element by element.

Elements flow through a parameterised number of lanes (1, 2 or 4). In each cycle every lane takes one new element, so a vector is handled one element, two elements or four elements per cycle. A memory element finishes one cycle after it enters its lane and an arithmetic element finishes five cycles after. The block runs one vector instruction at a time. It holds `busy` high until the last element has been written. An instruction offered during that time is held off with `issue_stall` and is accepted once `busy` falls. The scalar core shares the word memory through its own port and can use it at any time.

Top module: `vec_lane_seq`

## Requirements
- R1: After reset `busy` and `issue_stall` are low, every element of every vector register reads zero, and the length register holds 4.
- R2: Opcode 2'b00 (load) writes element i of register `issue_vd` with memory word (`issue_base` + i) modulo the memory size, for every i below the length.
- R3: Opcode 2'b01 (store) writes element i of register `issue_vs1` to memory word (`issue_base` + i) modulo the memory size, for every i below the length.
- R4: Opcode 2'b10 (multiply) writes element i of `issue_vd` with the low 32 bits of `issue_scalar` times element i of `issue_vs1`.
- R5: Opcode 2'b11 (add) writes element i of `issue_vd` with element i of `issue_vs1` plus element i of `issue_vs2`, modulo 2^32. The destination may also be a source.
- R6: Elements at or above the length are left unchanged. A length of 0 writes nothing. A length write above 4 stores 4. The length in force when an instruction is accepted is the one it uses.
- R7: `busy` rises in the cycle after acceptance and stays high for exactly max(G-1,0)+L cycles. Here G = ceil(length/lanes), and L is 1 for load and store and 5 for multiply and add.
- R8: `issue_stall` is high exactly while `issue_valid` and `busy` are both high. An instruction held under stall is accepted, unchanged, in the first cycle that `busy` is low.
- R9: The scalar memory port writes and reads (combinationally) while a vector instruction is in flight. A vector instruction reads the results of the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vl_we | input | 1 | Write the length register |
| vl_wdata | input | 3 | New length (values above 4 saturate) |
| issue_valid | input | 1 | A vector instruction is offered |
| issue_op | input | 2 | 00 load, 01 store, 10 multiply, 11 add |
| issue_vd | input | 3 | Destination vector register |
| issue_vs1 | input | 3 | First source register (store data, multiply operand) |
| issue_vs2 | input | 3 | Second source register (add only) |
| issue_scalar | input | 32 | Scalar multiplier |
| issue_base | input | 6 | Base word address for load and store |
| issue_stall | output | 1 | Offered instruction cannot be taken this cycle |
| busy | output | 1 | A vector instruction is in flight |
| sc_we | input | 1 | Scalar-side memory write |
| sc_addr | input | 6 | Scalar-side memory address |
| sc_wdata | input | 32 | Scalar-side write data |
| sc_rdata | output | 32 | Scalar-side read data (combinational) |
| peek_reg | input | 3 | Vector register to observe |
| peek_elem | input | 2 | Element to observe |
| peek_data | output | 32 | Observed element value (combinational) |

## Verification
The assertions assume that the issuer keeps every instruction field steady while `issue_stall` is high. They also assume the scalar port does not write a word that a store is writing in the same cycle. The bench only changes instruction fields before offering an instruction or after it has been accepted. It makes scalar writes only during multiply instructions, which never touch the memory. Random lengths from 0 to 7 are drawn on purpose, so values above 4 reach the saturation rule. Addresses are drawn over the whole range, so base plus offset can wrap past the last word.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  // Architectural shape of the vector unit
  localparam int NVREG  = 8;
  localparam int VLEN   = 4;
  localparam int VRW    = $clog2(NVREG);
  localparam int EW     = $clog2(VLEN);
  localparam int VLW    = EW + 1;
  // Memory operations finish in the cycle their element enters the lane
  localparam int MEM_LATENCY = 1;

  typedef enum logic [1:0] {
    VOP_LOAD  = 2'b00,
    VOP_STORE = 2'b01,
    VOP_MUL   = 2'b10,
    VOP_ADD   = 2'b11
  } vop_e;
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int NLANE       = 2,
  parameter int ALU_LATENCY = 5,
  parameter int DATA_W      = 32,
  parameter int ABITS       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vl_we,
  input  logic [2:0]        vl_wdata,
  input  logic              issue_valid,
  input  vop_e              issue_op,
  input  logic [VRW-1:0]    issue_vd,
  input  logic [VRW-1:0]    issue_vs1,
  input  logic [VRW-1:0]    issue_vs2,
  input  logic [DATA_W-1:0] issue_scalar,
  input  logic [ABITS-1:0]  issue_base,
  output logic              busy,
  output logic              issue_stall,
  output logic              launch,
  output logic [EW-1:0]     grp,
  output vop_e              op_q,
  output logic [VRW-1:0]    vd_q,
  output logic [VRW-1:0]    vs1_q,
  output logic [VRW-1:0]    vs2_q,
  output logic [DATA_W-1:0] scalar_q,
  output logic [ABITS-1:0]  base_q,
  output logic [VLW-1:0]    vl_q
);
  localparam int CW = $clog2(VLEN + ALU_LATENCY + 1);

  logic           run_q, run_d;
  logic [CW-1:0]  cyc_q, cyc_d;
  logic [VLW-1:0] vlreg_q, vlreg_d;
  logic [CW-1:0]  grp_cnt, lat, last_cyc;
  logic           accept;

  assign accept      = issue_valid & ~run_q;
  assign busy        = run_q;
  assign issue_stall = issue_valid & run_q;

  // Length of the current instruction in groups, and its completion cycle
  always_comb begin
    grp_cnt  = CW'((32'(vl_q) + NLANE - 1) / NLANE);
    lat      = (op_q == VOP_LOAD || op_q == VOP_STORE) ? CW'(MEM_LATENCY) : CW'(ALU_LATENCY);
    last_cyc = ((grp_cnt == '0) ? CW'(0) : grp_cnt - CW'(1)) + lat - CW'(1);
  end

  assign launch = run_q && (cyc_q < grp_cnt);
  assign grp    = cyc_q[EW-1:0];

  // Next state
  always_comb begin
    run_d = run_q;
    cyc_d = cyc_q;
    if (accept) begin
      run_d = 1'b1;
      cyc_d = '0;
    end else if (run_q) begin
      if (cyc_q == last_cyc) run_d = 1'b0;
      else                   cyc_d = cyc_q + CW'(1);
    end
  end

  always_comb begin
    vlreg_d = vlreg_q;
    if (vl_we) vlreg_d = (vl_wdata > 3'(VLEN)) ? VLW'(VLEN) : VLW'(vl_wdata);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cyc_q   <= '0;
      vlreg_q <= VLW'(VLEN);
    end else begin
      run_q   <= run_d;
      cyc_q   <= cyc_d;
      vlreg_q <= vlreg_d;
    end
  end

  // Instruction latch, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= VOP_LOAD;
      vd_q     <= '0;
      vs1_q    <= '0;
      vs2_q    <= '0;
      scalar_q <= '0;
      base_q   <= '0;
      vl_q     <= '0;
    end else if (accept) begin
      op_q     <= issue_op;
      vd_q     <= issue_vd;
      vs1_q    <= issue_vs1;
      vs2_q    <= issue_vs2;
      scalar_q <= issue_scalar;
      base_q   <= issue_base;
      vl_q     <= vlreg_q;
    end
  end

  // R6: the length register never holds more than the natural length
  p_vl_sat_r6: assert property (@(posedge clk) disable iff (!rst_n) vlreg_q <= VLW'(VLEN));
  // R7: an accepted instruction makes the unit busy in the next cycle
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !busy) |=> busy);
  // R7: an instruction never outlives the longest possible window
  p_cyc_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cyc_q < CW'(VLEN + ALU_LATENCY - 1));
  // R8: held fields stay put while stalled (input assumption)
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stall |=> !issue_valid || $stable(issue_op));
endmodule

// File: rtl/vseq_lane.sv
module vseq_lane
  import vseq_pkg::*;
#(
  parameter int ALU_LATENCY = 5,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vop_e              op,
  input  logic              in_valid,
  input  logic [EW-1:0]     in_idx,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] scalar,
  input  logic [DATA_W-1:0] mem_rd,
  output logic              wb_valid,
  output logic [EW-1:0]     wb_idx,
  output logic [DATA_W-1:0] wb_data
);
  localparam int STG = ALU_LATENCY - 1;

  logic              is_mem;
  logic [DATA_W-1:0] res;
  logic              ar_valid;
  logic [EW-1:0]     ar_idx;
  logic [DATA_W-1:0] ar_data;

  assign is_mem = (op == VOP_LOAD) || (op == VOP_STORE);

  always_comb begin
    unique case (op)
      VOP_LOAD:  res = mem_rd;
      VOP_STORE: res = opa;
      VOP_MUL:   res = opa * scalar;
      default:   res = opa + opb;
    endcase
  end

  generate
    if (STG == 0) begin : g_no_pipe
      assign ar_valid = in_valid & ~is_mem;
      assign ar_idx   = in_idx;
      assign ar_data  = res;
    end else begin : g_pipe
      logic              v_q [STG];
      logic              v_d [STG];
      logic [EW-1:0]     i_q [STG];
      logic [EW-1:0]     i_d [STG];
      logic [DATA_W-1:0] d_q [STG];
      logic [DATA_W-1:0] d_d [STG];

      always_comb begin
        v_d[0] = in_valid & ~is_mem;
        i_d[0] = in_idx;
        d_d[0] = res;
        for (int k = 1; k < STG; k++) begin
          v_d[k] = v_q[k-1];
          i_d[k] = i_q[k-1];
          d_d[k] = d_q[k-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < STG; k++) begin
            v_q[k] <= 1'b0;
            i_q[k] <= '0;
            d_q[k] <= '0;
          end
        end else begin
          for (int k = 0; k < STG; k++) begin
            v_q[k] <= v_d[k];
            i_q[k] <= i_d[k];
            d_q[k] <= d_d[k];
          end
        end
      end

      assign ar_valid = v_q[STG-1];
      assign ar_idx   = i_q[STG-1];
      assign ar_data  = d_q[STG-1];
    end
  endgenerate

  // Memory results retire on the entry edge; arithmetic after the pipe
  assign wb_valid = is_mem ? in_valid : ar_valid;
  assign wb_idx   = is_mem ? in_idx   : ar_idx;
  assign wb_data  = is_mem ? res      : ar_data;
endmodule

// File: rtl/vseq_vrf.sv
module vseq_vrf
  import vseq_pkg::*;
#(
  parameter int NLANE  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VRW-1:0]    rs1,
  input  logic [VRW-1:0]    rs2,
  input  logic [EW-1:0]     ridx  [NLANE],
  output logic [DATA_W-1:0] rda   [NLANE],
  output logic [DATA_W-1:0] rdb   [NLANE],
  input  logic [VRW-1:0]    wd,
  input  logic              we    [NLANE],
  input  logic [EW-1:0]     widx  [NLANE],
  input  logic [DATA_W-1:0] wdata [NLANE],
  input  logic [VRW-1:0]    peek_reg,
  input  logic [EW-1:0]     peek_elem,
  output logic [DATA_W-1:0] peek_data
);
  logic [DATA_W-1:0] vreg_q [NVREG][VLEN];
  logic [DATA_W-1:0] vreg_d [NVREG][VLEN];

  for (genvar l = 0; l < NLANE; l++) begin : g_rd
    assign rda[l] = vreg_q[rs1][ridx[l]];
    assign rdb[l] = vreg_q[rs2][ridx[l]];
  end

  assign peek_data = vreg_q[peek_reg][peek_elem];

  always_comb begin
    vreg_d = vreg_q;
    for (int l = 0; l < NLANE; l++)
      if (we[l]) vreg_d[wd][widx[l]] = wdata[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NVREG; r++)
        for (int e = 0; e < VLEN; e++)
          vreg_q[r][e] <= '0;
    end else begin
      vreg_q <= vreg_d;
    end
  end
endmodule

// File: rtl/vseq_mem.sv
module vseq_mem #(
  parameter int NLANE     = 2,
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  parameter int ABITS     = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic [ABITS-1:0]  raddr [NLANE],
  output logic [DATA_W-1:0] rdata [NLANE],
  input  logic              we    [NLANE],
  input  logic [ABITS-1:0]  waddr [NLANE],
  input  logic [DATA_W-1:0] wdata [NLANE],
  input  logic              sc_we,
  input  logic [ABITS-1:0]  sc_addr,
  input  logic [DATA_W-1:0] sc_wdata,
  output logic [DATA_W-1:0] sc_rdata
);
  logic [DATA_W-1:0] mem_q [MEM_WORDS];
  logic [DATA_W-1:0] mem_d [MEM_WORDS];

  for (genvar l = 0; l < NLANE; l++) begin : g_rd
    assign rdata[l] = mem_q[raddr[l]];
  end
  assign sc_rdata = mem_q[sc_addr];

  // Vector writes are applied last and win a same-word collision
  always_comb begin
    mem_d = mem_q;
    if (sc_we) mem_d[sc_addr] = sc_wdata;
    for (int l = 0; l < NLANE; l++)
      if (we[l]) mem_d[waddr[l]] = wdata[l];
  end

  // Storage array: no reset
  always_ff @(posedge clk) begin
    mem_q <= mem_d;
  end
endmodule

// File: rtl/vec_lane_seq.sv
module vec_lane_seq
  import vseq_pkg::*;
#(
  parameter int NLANE       = 2,
  parameter int ALU_LATENCY = 5,
  parameter int DATA_W      = 32,
  parameter int MEM_WORDS   = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vl_we,
  input  logic [2:0]                   vl_wdata,
  input  logic                         issue_valid,
  input  logic [1:0]                   issue_op,
  input  logic [2:0]                   issue_vd,
  input  logic [2:0]                   issue_vs1,
  input  logic [2:0]                   issue_vs2,
  input  logic [DATA_W-1:0]            issue_scalar,
  input  logic [$clog2(MEM_WORDS)-1:0] issue_base,
  output logic                         issue_stall,
  output logic                         busy,
  input  logic                         sc_we,
  input  logic [$clog2(MEM_WORDS)-1:0] sc_addr,
  input  logic [DATA_W-1:0]            sc_wdata,
  output logic [DATA_W-1:0]            sc_rdata,
  input  logic [2:0]                   peek_reg,
  input  logic [1:0]                   peek_elem,
  output logic [DATA_W-1:0]            peek_data
);
  localparam int ABITS = $clog2(MEM_WORDS);

  logic              launch;
  logic [EW-1:0]     grp;
  vop_e              op_q;
  logic [VRW-1:0]    vd_q, vs1_q, vs2_q;
  logic [DATA_W-1:0] scalar_q;
  logic [ABITS-1:0]  base_q;
  logic [VLW-1:0]    vl_q;

  logic [VLW-1:0]    elem_n   [NLANE];
  logic              ln_valid [NLANE];
  logic [EW-1:0]     ln_idx   [NLANE];
  logic [DATA_W-1:0] opa      [NLANE];
  logic [DATA_W-1:0] opb      [NLANE];
  logic [ABITS-1:0]  rd_addr  [NLANE];
  logic [DATA_W-1:0] mem_rd   [NLANE];
  logic              wb_valid [NLANE];
  logic [EW-1:0]     wb_idx   [NLANE];
  logic [DATA_W-1:0] wb_data  [NLANE];
  logic              vrf_we   [NLANE];
  logic              mem_we   [NLANE];
  logic [ABITS-1:0]  wr_addr  [NLANE];

  vseq_ctrl #(.NLANE(NLANE), .ALU_LATENCY(ALU_LATENCY), .DATA_W(DATA_W), .ABITS(ABITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .vl_we(vl_we), .vl_wdata(vl_wdata),
    .issue_valid(issue_valid), .issue_op(vop_e'(issue_op)),
    .issue_vd(issue_vd), .issue_vs1(issue_vs1), .issue_vs2(issue_vs2),
    .issue_scalar(issue_scalar), .issue_base(issue_base),
    .busy(busy), .issue_stall(issue_stall), .launch(launch), .grp(grp),
    .op_q(op_q), .vd_q(vd_q), .vs1_q(vs1_q), .vs2_q(vs2_q),
    .scalar_q(scalar_q), .base_q(base_q), .vl_q(vl_q)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    // Element handled by this lane in the current group
    assign elem_n[l]   = VLW'(32'(grp) * NLANE + l);
    assign ln_valid[l] = launch && (elem_n[l] < vl_q);
    assign ln_idx[l]   = elem_n[l][EW-1:0];
    assign rd_addr[l]  = base_q + ABITS'(ln_idx[l]);

    vseq_lane #(.ALU_LATENCY(ALU_LATENCY), .DATA_W(DATA_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .op(op_q),
      .in_valid(ln_valid[l]), .in_idx(ln_idx[l]),
      .opa(opa[l]), .opb(opb[l]), .scalar(scalar_q), .mem_rd(mem_rd[l]),
      .wb_valid(wb_valid[l]), .wb_idx(wb_idx[l]), .wb_data(wb_data[l])
    );

    assign vrf_we[l]  = wb_valid[l] && (op_q != VOP_STORE);
    assign mem_we[l]  = wb_valid[l] && (op_q == VOP_STORE);
    assign wr_addr[l] = base_q + ABITS'(wb_idx[l]);

    // R7: nothing retires outside an instruction
    p_wb_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid[l] |-> busy);
    // R6: no element at or above the length is written
    p_wb_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid[l] |-> (VLW'(wb_idx[l]) < vl_q));
    // R9: scalar port never collides with a vector store (input assumption)
    p_sc_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we[l] && sc_we) |-> (sc_addr != wr_addr[l]));
  end

  vseq_vrf #(.NLANE(NLANE), .DATA_W(DATA_W)) u_vrf (
    .clk(clk), .rst_n(rst_n),
    .rs1(vs1_q), .rs2(vs2_q), .ridx(ln_idx), .rda(opa), .rdb(opb),
    .wd(vd_q), .we(vrf_we), .widx(wb_idx), .wdata(wb_data),
    .peek_reg(peek_reg), .peek_elem(peek_elem), .peek_data(peek_data)
  );

  vseq_mem #(.NLANE(NLANE), .DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS), .ABITS(ABITS)) u_mem (
    .clk(clk), .raddr(rd_addr), .rdata(mem_rd),
    .we(mem_we), .waddr(wr_addr), .wdata(wb_data),
    .sc_we(sc_we), .sc_addr(sc_addr), .sc_wdata(sc_wdata), .sc_rdata(sc_rdata)
  );
endmodule

// File: tb/vec_lane_seq_tb.sv
module vec_lane_seq_tb;
  localparam int LANES = 2;
  localparam int MW    = 64;

  logic        clk, rst_n;
  logic        vl_we;
  logic [2:0]  vl_wdata;
  logic        issue_valid;
  logic [1:0]  issue_op;
  logic [2:0]  issue_vd, issue_vs1, issue_vs2;
  logic [31:0] issue_scalar;
  logic [5:0]  issue_base;
  logic        issue_stall, busy;
  logic        sc_we;
  logic [5:0]  sc_addr;
  logic [31:0] sc_wdata, sc_rdata;
  logic [2:0]  peek_reg;
  logic [1:0]  peek_elem;
  logic [31:0] peek_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mv [8][4];
  logic [31:0] mm [MW];
  int mvl = 4;

  vec_lane_seq #(.NLANE(LANES), .MEM_WORDS(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .vl_we(vl_we), .vl_wdata(vl_wdata),
    .issue_valid(issue_valid), .issue_op(issue_op), .issue_vd(issue_vd),
    .issue_vs1(issue_vs1), .issue_vs2(issue_vs2), .issue_scalar(issue_scalar),
    .issue_base(issue_base), .issue_stall(issue_stall), .busy(busy),
    .sc_we(sc_we), .sc_addr(sc_addr), .sc_wdata(sc_wdata), .sc_rdata(sc_rdata),
    .peek_reg(peek_reg), .peek_elem(peek_elem), .peek_data(peek_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_busy(input int op, input int vl);
    int g;
    int lat;
    g   = (vl + LANES - 1) / LANES;
    lat = (op < 2) ? 1 : 5;
    return ((g == 0) ? 0 : g - 1) + lat;
  endfunction

  function automatic logic [31:0] exp_elem(input int op, input logic [31:0] a,
                                           input logic [31:0] b, input logic [31:0] s);
    if (op == 2) return a * s;
    return a + b;
  endfunction

  // Apply one instruction to the reference model
  task automatic model_op(input int op, input int vd, input int s1, input int s2,
                          input logic [31:0] sc, input int base);
    for (int i = 0; i < mvl; i++) begin
      case (op)
        0: mv[vd][i] = mm[(base + i) % MW];
        1: mm[(base + i) % MW] = mv[s1][i];
        default: mv[vd][i] = exp_elem(op, mv[s1][i], mv[s2][i], sc);
      endcase
    end
  endtask

  task automatic set_vl(input int v);
    @(negedge clk);
    vl_we = 1'b1; vl_wdata = 3'(v);
    @(negedge clk);
    vl_we = 1'b0;
    mvl = (v > 4) ? 4 : v;
  endtask

  task automatic mem_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    sc_we = 1'b1; sc_addr = 6'(a); sc_wdata = d;
    @(negedge clk);
    sc_we = 1'b0;
    mm[a] = d;
  endtask

  task automatic drive(input int op, input int vd, input int s1, input int s2,
                       input logic [31:0] sc, input int base);
    issue_valid = 1'b1; issue_op = 2'(op); issue_vd = 3'(vd);
    issue_vs1 = 3'(s1); issue_vs2 = 3'(s2); issue_scalar = sc; issue_base = 6'(base);
  endtask

  // Issue from idle, count busy cycles, update model
  task automatic run_op(input int op, input int vd, input int s1, input int s2,
                        input logic [31:0] sc, input int base, input string req);
    int cnt;
    @(negedge clk);
    drive(op, vd, s1, s2, sc, base);
    @(negedge clk);
    issue_valid = 1'b0;
    cnt = 0;
    while (busy) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == exp_busy(op, mvl), {req, " R7 busy length"}, 32'(cnt), 32'(exp_busy(op, mvl)));
    model_op(op, vd, s1, s2, sc, base);
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < 8; r++)
      for (int e = 0; e < 4; e++) begin
        peek_reg = 3'(r); peek_elem = 2'(e);
        #1;
        chk(peek_data === mv[r][e], req, peek_data, mv[r][e]);
      end
  endtask

  task automatic check_mem(input string req);
    for (int a = 0; a < MW; a++) begin
      sc_addr = 6'(a);
      #1;
      chk(sc_rdata === mm[a], req, sc_rdata, mm[a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; vl_we = 1'b0; vl_wdata = '0; issue_valid = 1'b0; issue_op = '0;
    issue_vd = '0; issue_vs1 = '0; issue_vs2 = '0; issue_scalar = '0; issue_base = '0;
    sc_we = 1'b0; sc_addr = '0; sc_wdata = '0; peek_reg = '0; peek_elem = '0;
    for (int r = 0; r < 8; r++) for (int e = 0; e < 4; e++) mv[r][e] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
    chk(issue_stall == 1'b0, "R1 stall after reset", 32'(issue_stall), 0);
    check_regs("R1 register reset value");

    for (int a = 0; a < MW; a++) mem_wr(a, $urandom());
    mem_wr(0, 32'h8000_0001);
    mem_wr(1, 32'hFFFF_FFFF);
    mem_wr(2, 32'h7FFF_FFFF);
    mem_wr(3, 32'h0000_0003);

    // R2 with default length 4 (R1)
    run_op(0, 0, 0, 0, 0, 0, "R1,R2");
    check_regs("R2 load");
    run_op(0, 1, 0, 0, 0, 61, "R2");
    check_regs("R2 load wrapping");
    // R5 and R9 chained reads
    run_op(3, 2, 0, 1, 0, 0, "R5");
    check_regs("R5,R9 add");
    // R4 overflowing product
    run_op(2, 3, 0, 0, 32'h0000_0002, 0, "R4");
    check_regs("R4 multiply by 2");
    run_op(2, 4, 1, 0, 32'hFFFF_FFFD, 0, "R4");
    check_regs("R4 multiply by -3");
    // R3 store wrapping
    run_op(1, 0, 3, 0, 0, 62, "R3");
    check_mem("R3 store");
    // R6 partial length with aliasing
    set_vl(3);
    run_op(3, 3, 3, 3, 0, 0, "R6");
    check_regs("R5,R6 partial add in place");
    set_vl(1);
    run_op(1, 0, 4, 0, 0, 20, "R6");
    check_mem("R3,R6 single-element store");
    set_vl(0);
    run_op(2, 5, 2, 0, 32'd7, 0, "R6");
    check_regs("R6 zero length writes nothing");
    run_op(0, 5, 0, 0, 0, 8, "R6");
    check_regs("R6 zero-length load");
    set_vl(7);
    run_op(0, 6, 0, 0, 0, 30, "R6");
    check_regs("R6 length saturation");

    // R8: stall while busy, then accepted unchanged
    @(negedge clk);
    drive(3, 7, 2, 4, 0, 0);
    @(negedge clk);
    drive(0, 5, 0, 0, 0, 40);
    #1;
    chk(issue_stall == 1'b1, "R8 stall while busy", 32'(issue_stall), 1);
    cnt = 1;
    while (busy) begin
      chk(issue_stall == 1'b1, "R8 stall held", 32'(issue_stall), 1);
      @(negedge clk);
      if (busy) cnt++;
    end
    chk(cnt == exp_busy(3, 4), "R7,R8 first busy length", 32'(cnt), 32'(exp_busy(3, 4)));
    chk(issue_stall == 1'b0, "R8 stall released", 32'(issue_stall), 0);
    model_op(3, 7, 2, 4, 0, 0);
    @(negedge clk);
    issue_valid = 1'b0;
    chk(busy == 1'b1, "R8 held instruction accepted", 32'(busy), 1);
    while (busy) @(negedge clk);
    model_op(0, 5, 0, 0, 0, 40);
    check_regs("R8 both instructions retired");

    // R9: scalar port during a multiply
    @(negedge clk);
    drive(2, 6, 7, 0, 32'd9, 0);
    @(negedge clk);
    issue_valid = 1'b0;
    sc_we = 1'b1; sc_addr = 6'd50; sc_wdata = 32'hCAFE_0050;
    @(negedge clk);
    sc_we = 1'b0; mm[50] = 32'hCAFE_0050;
    sc_addr = 6'd50;
    #1;
    chk(busy == 1'b1, "R9 still busy during scalar access", 32'(busy), 1);
    chk(sc_rdata === 32'hCAFE_0050, "R9 scalar read while busy", sc_rdata, 32'hCAFE_0050);
    while (busy) @(negedge clk);
    model_op(2, 6, 7, 0, 32'd9, 0);
    check_regs("R4,R9 multiply after scalar access");
    check_mem("R9 memory after scalar access");

    // Random mix
    for (int n = 0; n < 120; n++) begin
      int op;
      string tag;
      if ($urandom_range(0, 3) == 0) set_vl(int'($urandom_range(0, 7)));
      op = int'($urandom_range(0, 3));
      tag = (op == 0) ? "R2,R6 random load" : (op == 1) ? "R3,R6 random store" :
            (op == 2) ? "R4,R6 random multiply" : "R5,R6 random add";
      run_op(op, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
             int'($urandom_range(0, 7)), $urandom(), int'($urandom_range(0, MW - 1)), tag);
      if (op == 1) check_mem(tag);
      else check_regs(tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule